// File: doc/BRIEF.md
# TDM Audio Serial Transmitter

This block drives one serial audio data lane in time-division-multiplexed form. From the system clock it derives its own bit clock and frame sync, and it sends one word in each enabled slot of a frame. Before a word is sent it is rotated right by a whole number of nibbles and ANDed with a mask. It then goes out over a slot whose length comes from a compact size code, in either bit order.

Software controls the block through eight word registers: run control, format, frame control, clock control, slot enable, mask, status and a one-word transmit buffer. Bring-up releases four run bits one at a time. A typical sequence turns on the clock, then the serializer, loads a silent word, then turns on the state machine and finally the frame sync. The `dreq` output asks a host or DMA engine for the next word whenever the buffer is empty while the state machine is on. When an enabled slot starts with nothing in the buffer, the slot goes out as zeros and a sticky underrun flag is set.

Top module: `tdm_serial_tx`

## Requirements
- R1: After reset, the registers read as zero and status reads 2 (buffer empty, no underrun). `sd_out`, `fs_out`, `bclk_out` and `dreq` are low.
- R2: The clock control register (address 3) holds a divider field in bits 4:0. While run-control bit 0 is set, the bit clock spends divider+1 system clocks high and divider+1 low. While bit 0 is clear, the bit clock rests at its idle level. Bit 7 inverts the bit clock.
- R3: Run-control (address 0) bits are clock (0), serializer (1), state machine (2) and frame sync (3). Slots are sent only while bits 0, 2 and 3 are all set. Otherwise `sd_out` and the internal frame sync stay low. While bit 1 is clear, the buffer is held empty and writes to it (address 7) are dropped.
- R4: The format register (address 1) holds a size code in bits 7:4. A slot lasts 2*(code+1) bit clocks, so code 3 gives 8 bits, 7 gives 16 and 15 gives 32. The low slot-length bits of the prepared word are sent.
- R5: The frame control register (address 2) holds the slot count in bits 15:7, where 0 and 1 both mean one slot. With bit 4 clear, frame sync is high for the first bit of slot 0 only. With bit 4 set, it is high for all of slot 0. Bit 0 inverts `fs_out`.
- R6: Format bit 15 set sends the most significant bit of the slot first. Clear sends the least significant bit first.
- R7: Format bits 2:0 rotate the buffered word right by four times their value. The result is then ANDed with the mask register (address 5) before it is sent.
- R8: Slot-enable register (address 4) bit n enables slot n. A disabled slot sends zeros and leaves the buffer untouched, so consecutive words go to consecutive enabled slots.
- R9: When an enabled slot starts with the buffer empty, the slot is sent as zeros and status bit 0 (address 6) is set. The bit stays set until a write to status with bit 0 high.
- R10: `dreq` is high exactly when state-machine bit 2 is set and the buffer is empty. Status bit 1 reads the buffer-empty state.
- R11: Writing zero to run control stops the transmitter. `sd_out` returns low, frame sync and bit clock return to their idle levels, and the buffer empties. The next start begins a fresh frame at slot 0.
- R12: `bclk_oe` follows clock-control bit 5 and `fs_oe` follows frame-control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| bclk_out | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Bit clock drive enable |
| fs_out | output | 1 | Generated frame sync |
| fs_oe | output | 1 | Frame sync drive enable |
| sd_out | output | 1 | Serial data |
| dreq | output | 1 | Request for the next buffer word |

## Verification
The transmit path is driven with several distinct formats. Four 16-bit slots, MSB first, with a one-bit sync catch a wrong slot length or a sync pulse that is too wide. Two 8-bit slots, LSB first, with a slot-wide inverted sync, separate the bit-order and polarity paths from the default ones. Two 32-bit slots with a six-nibble rotation and a 24-bit mask expose a rotation in the wrong direction or a mask applied in the wrong place. A sparse slot-enable pattern shows whether words skip disabled slots. A run left without new words, then stopped, checks the zero fill, the sticky underrun flag and its clear-on-write.

// File: rtl/tdm_serial_tx.sv
`timescale 1ns/1ps
module tdm_serial_tx (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        bclk_out,
  output logic        bclk_oe,
  output logic        fs_out,
  output logic        fs_oe,
  output logic        sd_out,
  output logic        dreq
);
  localparam logic [2:0] A_CTRL = 3'd0, A_FMT = 3'd1, A_FRAME = 3'd2, A_CLK = 3'd3,
                         A_SLOTEN = 3'd4, A_MASK = 3'd5, A_STAT = 3'd6, A_BUF = 3'd7;

  logic [3:0]  ctrl_q;
  logic [2:0]  rot_q;
  logic [3:0]  ssz_q;
  logic        msb_q;
  logic        fs_pol_q, fs_int_q, fs_wide_q;
  logic [8:0]  nslot_q;
  logic [4:0]  div_q;
  logic        clk_int_q, clk_pol_q;
  logic [31:0] slot_en_q, mask_q, buf_q, word_q;
  logic        buf_full, und_q;
  logic [4:0]  div_cnt, bit_cnt;
  logic        ph, active, sd_q, fs_q;
  logic [8:0]  slot_cnt;

  logic clk_run, ser_run, sm_run, fsg_run, run;
  assign clk_run = ctrl_q[0];
  assign ser_run = ctrl_q[1];
  assign sm_run  = ctrl_q[2];
  assign fsg_run = ctrl_q[3];
  assign run     = clk_run && sm_run && fsg_run;

  logic w_buf, w_stat;
  assign w_buf  = reg_we && reg_addr == A_BUF;
  assign w_stat = reg_we && reg_addr == A_STAT;

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; rot_q <= '0; ssz_q <= '0; msb_q <= 1'b0;
      fs_pol_q <= 1'b0; fs_int_q <= 1'b0; fs_wide_q <= 1'b0; nslot_q <= '0;
      div_q <= '0; clk_int_q <= 1'b0; clk_pol_q <= 1'b0;
      slot_en_q <= '0; mask_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL:   ctrl_q <= reg_wdata[3:0];
        A_FMT:    begin rot_q <= reg_wdata[2:0]; ssz_q <= reg_wdata[7:4]; msb_q <= reg_wdata[15]; end
        A_FRAME:  begin
                    fs_pol_q <= reg_wdata[0]; fs_int_q <= reg_wdata[1];
                    fs_wide_q <= reg_wdata[4]; nslot_q <= reg_wdata[15:7];
                  end
        A_CLK:    begin div_q <= reg_wdata[4:0]; clk_int_q <= reg_wdata[5]; clk_pol_q <= reg_wdata[7]; end
        A_SLOTEN: slot_en_q <= reg_wdata;
        A_MASK:   mask_q <= reg_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:   reg_rdata = {28'b0, ctrl_q};
      A_FMT:    reg_rdata = {16'b0, msb_q, 7'b0, ssz_q, 1'b0, rot_q};
      A_FRAME:  reg_rdata = {16'b0, nslot_q, 2'b0, fs_wide_q, 2'b0, fs_int_q, fs_pol_q};
      A_CLK:    reg_rdata = {24'b0, clk_pol_q, 1'b0, clk_int_q, div_q};
      A_SLOTEN: reg_rdata = slot_en_q;
      A_MASK:   reg_rdata = mask_q;
      A_STAT:   reg_rdata = {30'b0, ~buf_full, und_q};
      default:  reg_rdata = buf_q;
    endcase
  end

  // bit clock: each phase lasts div_q+1 system clocks
  logic tick, adv;
  assign tick = clk_run && div_cnt == div_q;
  assign adv  = tick && ph && run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0; ph <= 1'b0;
    end else if (!clk_run) begin
      div_cnt <= '0; ph <= 1'b0;
    end else if (tick) begin
      div_cnt <= '0; ph <= ~ph;
    end else begin
      div_cnt <= div_cnt + 5'd1;
    end
  end

  // slot and frame sequencing
  logic [4:0]  slen_m1, nb, idx;
  logic        last_bit, last_slot, new_slot, slot_on, take, starve;
  logic [8:0]  next_slot;
  logic [31:0] rot_w, load_w;

  assign slen_m1   = {ssz_q, 1'b1};
  assign last_bit  = bit_cnt >= slen_m1;
  assign last_slot = ({1'b0, slot_cnt} + 10'd1) >= {1'b0, nslot_q};
  assign new_slot  = adv && (!active || last_bit);
  assign next_slot = (!active || last_slot) ? 9'd0 : slot_cnt + 9'd1;
  assign slot_on   = next_slot[8:5] == 4'd0 && slot_en_q[next_slot[4:0]];
  assign take      = new_slot && slot_on && buf_full;
  assign starve    = new_slot && slot_on && !buf_full;
  assign rot_w     = (buf_q >> {rot_q, 2'b00}) | (buf_q << (6'd32 - {1'b0, rot_q, 2'b00}));
  assign load_w    = take ? (rot_w & mask_q) : 32'd0;
  assign nb        = bit_cnt + 5'd1;
  assign idx       = msb_q ? slen_m1 - nb : nb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; bit_cnt <= '0; slot_cnt <= '0; word_q <= '0; sd_q <= 1'b0; fs_q <= 1'b0;
    end else if (!run) begin
      active <= 1'b0; bit_cnt <= '0; slot_cnt <= '0; word_q <= '0; sd_q <= 1'b0; fs_q <= 1'b0;
    end else if (new_slot) begin
      active   <= 1'b1;
      bit_cnt  <= '0;
      slot_cnt <= next_slot;
      word_q   <= load_w;
      sd_q     <= msb_q ? load_w[slen_m1] : load_w[0];
      fs_q     <= next_slot == 9'd0;
    end else if (adv) begin
      bit_cnt <= nb;
      sd_q    <= word_q[idx];
      fs_q    <= fs_wide_q && slot_cnt == 9'd0;
    end
  end

  // buffer and status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0; buf_full <= 1'b0; und_q <= 1'b0;
    end else begin
      if (!ser_run)   buf_full <= 1'b0;
      else if (w_buf) buf_full <= 1'b1;
      else if (take)  buf_full <= 1'b0;
      if (w_buf && ser_run) buf_q <= reg_wdata;
      if (starve) und_q <= 1'b1;
      else if (w_stat && reg_wdata[0]) und_q <= 1'b0;
    end
  end

  assign bclk_out = ph ^ clk_pol_q;
  assign bclk_oe  = clk_int_q;
  assign fs_out   = fs_q ^ fs_pol_q;
  assign fs_oe    = fs_int_q;
  assign sd_out   = sd_q;
  assign dreq     = sm_run && !buf_full;

  p_bclk_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |=> bclk_out == clk_pol_q);
  p_fs_slot0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_q) |-> slot_cnt == 9'd0);
  p_und_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    und_q && !(w_stat && reg_wdata[0]) |=> und_q);
  p_write_fills_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (w_buf && ser_run) |=> !dreq);
  p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q == 4'h0 |=> (!sd_out && !buf_full && !fs_q));
endmodule

// File: tb/tb_tdm_serial_tx.sv
`timescale 1ns/1ps
module tb_tdm_serial_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic bclk_out, bclk_oe, fs_out, fs_oe, sd_out, dreq;

  tdm_serial_tx dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bclk_out(bclk_out), .bclk_oe(bclk_oe),
    .fs_out(fs_out), .fs_oe(fs_oe), .sd_out(sd_out), .dreq(dreq));

  always #2 clk = ~clk;

  localparam logic [2:0] A_CTRL = 3'd0, A_FMT = 3'd1, A_FRAME = 3'd2, A_CLK = 3'd3,
                         A_SLOTEN = 3'd4, A_MASK = 3'd5, A_STAT = 3'd6, A_BUF = 3'd7;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic [31:0] wq [16];

  bit cap_arm = 1'b0;
  logic prev_b = 1'b0;
  int cap_n = 0;
  logic fs_cap [4096];
  logic sd_cap [4096];

  always @(negedge clk) begin
    if (!cap_arm) cap_n <= 0;
    else if (bclk_out && !prev_b && cap_n < 4096) begin
      fs_cap[cap_n] <= fs_out;
      sd_cap[cap_n] <= sd_out;
      cap_n <= cap_n + 1;
    end
    prev_b <= bclk_out;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [31:0] prep(input logic [31:0] w, input int rot, input logic [31:0] m);
    int sh = 4 * rot;
    return ((w >> sh) | (w << (32 - sh))) & m;
  endfunction

  task automatic start_run(input logic [31:0] fmt, input logic [31:0] frame, input logic [31:0] clkc,
                           input logic [31:0] en, input logic [31:0] mask);
    wr(A_CTRL, 0); wr(A_FMT, fmt); wr(A_FRAME, frame); wr(A_CLK, clkc);
    wr(A_SLOTEN, en); wr(A_MASK, mask); wr(A_STAT, 32'h1);
    cap_arm = 1'b0;
    wr(A_CTRL, 32'h1); wr(A_CTRL, 32'h3); wr(A_BUF, wq[0]); wr(A_CTRL, 32'h7);
    cap_arm = 1'b1;
    wr(A_CTRL, 32'hF);
  endtask

  task automatic run_feed(input int ncyc, input int nw);
    int wi = 1;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      reg_we = 1'b0;
      if (dreq && wi < nw) begin
        reg_we = 1'b1; reg_addr = A_BUF; reg_wdata = wq[wi]; wi++;
      end
    end
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic check_stream(input int nsl, input int slen, input bit msb, input logic [31:0] en,
                              input int nfr, input bit wide, input bit fpol, input int rot,
                              input logic [31:0] mask, input string req);
    int f = -1;
    int wi = 0;
    logic [31:0] lm;
    lm = (slen == 32) ? 32'hFFFF_FFFF : ((32'h1 << slen) - 32'h1);
    for (int i = 0; i < cap_n; i++) if (f < 0 && fs_cap[i] == !fpol) f = i;
    chk(f >= 0, req, "frame start seen", f, 0);
    if (f < 0) return;
    for (int fr = 0; fr < nfr; fr++) begin
      bit fs_ok = 1'b1;
      for (int s = 0; s < nsl; s++) begin
        logic [31:0] ex = 32'd0;
        logic [31:0] got = 32'd0;
        if (en[s]) begin ex = prep(wq[wi], rot, mask) & lm; wi++; end
        for (int b = 0; b < slen; b++) begin
          int k = f + (fr * nsl + s) * slen + b;
          logic efs = (wide ? (s == 0) : (s == 0 && b == 0)) ^ fpol;
          if (k >= cap_n) fs_ok = 1'b0;
          else begin
            if (msb) got[slen-1-b] = sd_cap[k]; else got[b] = sd_cap[k];
            if (fs_cap[k] !== efs) fs_ok = 1'b0;
          end
        end
        chk(got === ex, req, $sformatf("frame %0d slot %0d data", fr, s), got, ex);
      end
      chk(fs_ok, req, $sformatf("frame %0d sync pattern", fr), {31'b0, fs_ok}, 1);
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_CTRL, d);  chk(d == 0, "R1", "ctrl after reset", d, 0);
    rd(A_FMT, d);   chk(d == 0, "R1", "format after reset", d, 0);
    rd(A_FRAME, d); chk(d == 0, "R1", "frame ctl after reset", d, 0);
    rd(A_CLK, d);   chk(d == 0, "R1", "clock ctl after reset", d, 0);
    rd(A_STAT, d);  chk(d == 2, "R1", "status after reset", d, 2);
    chk({sd_out, fs_out, bclk_out, dreq} == 4'b0, "R1", "outputs after reset",
        {sd_out, fs_out, bclk_out, dreq}, 0);
  endtask

  task automatic t_clock;
    int hi = 0, lo = 0, g = 0;
    logic p;
    wr(A_CLK, 32'h23); wr(A_CTRL, 32'h1);
    chk(bclk_oe == 1'b1, "R12", "bit clock drive enable", bclk_oe, 1);
    chk(fs_oe == 1'b0, "R12", "frame sync drive enable off", fs_oe, 0);
    wr(A_FRAME, 32'h2);
    chk(fs_oe == 1'b1, "R12", "frame sync drive enable on", fs_oe, 1);
    p = bclk_out;
    while (g < 100) begin
      @(negedge clk); g++;
      if (bclk_out && !p) break;
      p = bclk_out;
    end
    while (bclk_out && hi < 100) begin @(negedge clk); hi++; end
    while (!bclk_out && lo < 100) begin @(negedge clk); lo++; end
    chk(hi == 4, "R2", "bit clock high time", hi, 4);
    chk(lo == 4, "R2", "bit clock low time", lo, 4);
    wr(A_CTRL, 0); @(negedge clk);
    chk(bclk_out == 1'b0, "R2", "bit clock rest level", bclk_out, 0);
    wr(A_CLK, 32'h80); @(negedge clk);
    chk(bclk_out == 1'b1, "R2", "inverted rest level", bclk_out, 1);
    wr(A_CLK, 32'h0);
  endtask

  task automatic t_gating;
    logic [31:0] d;
    bit quiet = 1'b1;
    wr(A_FRAME, 32'h0000_0202); wr(A_SLOTEN, 32'h3); wr(A_MASK, 32'hFFFF_FFFF);
    wr(A_FMT, 32'h30); wr(A_CTRL, 32'h5);
    wr(A_BUF, 32'hAB);
    rd(A_STAT, d);
    chk(d[1] == 1'b1, "R3", "buffer write dropped while serializer clear", d[1], 1);
    chk(dreq == 1'b1, "R10", "request with empty buffer", dreq, 1);
    for (int c = 0; c < 60; c++) begin
      @(negedge clk); if (sd_out || fs_out) quiet = 1'b0;
    end
    chk(quiet, "R3", "no frame without frame-sync run bit", {31'b0, quiet}, 1);
    wr(A_CTRL, 32'h7); wr(A_BUF, 32'hAB);
    rd(A_STAT, d);
    chk(d[1] == 1'b0, "R10", "status shows buffer full", d[1], 0);
    chk(dreq == 1'b0, "R10", "no request with full buffer", dreq, 0);
  endtask

  task automatic t_tdm16;
    logic [31:0] d;
    wq[0] = 32'hA5C3; wq[1] = 32'h1234; wq[2] = 32'hFFFF; wq[3] = 32'h0001;
    wq[4] = 32'h8000; wq[5] = 32'h7E7E; wq[6] = 32'h0F0F; wq[7] = 32'hBEEF;
    start_run(32'h8070, (32'd4 << 7) | 32'h2, 32'h20, 32'hF, 32'hFFFF_FFFF);
    run_feed(400, 8);
    check_stream(4, 16, 1'b1, 32'hF, 2, 1'b0, 1'b0, 0, 32'hFFFF_FFFF, "R4 R5 R6");
    chk(dreq == 1'b1, "R10", "request once words run out", dreq, 1);
    rd(A_STAT, d);
    chk(d[0] == 1'b1, "R9", "underrun after words run out", d[0], 1);
  endtask

  task automatic t_lsb_wide;
    wq[0] = 32'h5A; wq[1] = 32'hC3; wq[2] = 32'h01; wq[3] = 32'h80;
    start_run(32'h0030, (32'd2 << 7) | 32'h13, 32'h20, 32'h3, 32'hFFFF_FFFF);
    run_feed(200, 4);
    check_stream(2, 8, 1'b0, 32'h3, 2, 1'b1, 1'b1, 0, 32'hFFFF_FFFF, "R5 R6 R4");
  endtask

  task automatic t_rot_mask;
    wq[0] = 32'h1234_5678; wq[1] = 32'h89AB_CDEF; wq[2] = 32'hDEAD_BEEF; wq[3] = 32'h0F1E_2D3C;
    start_run(32'h80F6, (32'd2 << 7) | 32'h2, 32'h20, 32'h3, 32'h00FF_FFFF);
    run_feed(400, 4);
    check_stream(2, 32, 1'b1, 32'h3, 2, 1'b0, 1'b0, 6, 32'h00FF_FFFF, "R7");
  endtask

  task automatic t_sparse;
    wq[0] = 32'h3C; wq[1] = 32'hE1; wq[2] = 32'h77; wq[3] = 32'h18;
    start_run(32'h8030, (32'd4 << 7) | 32'h2, 32'h20, 32'h5, 32'hFFFF_FFFF);
    run_feed(300, 4);
    check_stream(4, 8, 1'b1, 32'h5, 2, 1'b0, 1'b0, 0, 32'hFFFF_FFFF, "R8");
  endtask

  task automatic t_underrun_stop;
    logic [31:0] d;
    wq[0] = 32'h96; wq[1] = 32'h0;
    start_run(32'h8030, (32'd2 << 7) | 32'h2, 32'h20, 32'h3, 32'hFFFF_FFFF);
    run_feed(200, 1);
    check_stream(2, 8, 1'b1, 32'h3, 1, 1'b0, 1'b0, 0, 32'hFFFF_FFFF, "R9 R11");
    rd(A_STAT, d);
    chk(d[0] == 1'b1, "R9", "underrun flag set", d[0], 1);
    wr(A_CTRL, 0); @(negedge clk);
    chk({sd_out, fs_out, bclk_out, dreq} == 4'b0, "R11", "outputs idle after stop",
        {sd_out, fs_out, bclk_out, dreq}, 0);
    rd(A_STAT, d);
    chk(d == 32'h3, "R9", "underrun kept after stop", d, 3);
    wr(A_STAT, 32'h0); rd(A_STAT, d);
    chk(d == 32'h3, "R9", "write of zero leaves flag", d, 3);
    wr(A_STAT, 32'h1); rd(A_STAT, d);
    chk(d == 32'h2, "R9", "write of one clears flag", d, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_clock();
    t_gating();
    t_tdm16();
    t_lsb_wide();
    t_rot_mask();
    t_sparse();
    t_underrun_stop();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule